// File: doc/BRIEF.md
# Dual-Clock Half-Word Packing FIFO

This block carries data between two unrelated clock domains. The producer writes 18-bit half-words on its own clock. Each pair of half-words is joined into one 36-bit word before it is stored. The consumer takes 36-bit words on a separate clock. Read and write pointers are kept in binary and cross the domain boundary as Gray code through two-flop synchronizers. Each side therefore sees a conservative view of how full the buffer is.

One shared select input serves two purposes. While reset is held, it sets the packing order: high puts the first half-word on top, and low puts it on the bottom. After reset, the same input sets the read timing. High gives standard mode, where each read loads the output register and the status output means "buffer not empty". Low gives fall-through mode, where the oldest word appears on the outputs without being asked for and the status output means "output word valid". Both sides have programmable threshold flags. The thresholds are set by parameters.

Top module: `hw_pack_fifo`

## Requirements
- R1: When `cfg_sel` is 1 during reset, the first half-word of a pair lands in bits [35:18] of the stored word and the second in bits [17:0]. When it is 0, the first lands in [17:0] and the second in [35:18].
- R2: A word becomes readable only after its second half-word is written. A single pending half-word leaves `rd_avail` low and is not counted.
- R3: `wr_room` goes low once DEPTH words are stored. A write attempted while it is low changes neither the stored data nor the count.
- R4: `wr_afull_n` is low exactly when the number of free word locations seen on the write side is at most AF_OFS.
- R5: `rd_aempty_n` is low exactly when the stored word count seen on the read side is at most AE_OFS. In fall-through mode this count includes the word held on the outputs.
- R6: In standard mode (`cfg_sel` high after reset), `rd_avail` is high while any word is stored. A read loads the oldest word onto `rd_word` at that read clock edge.
- R7: In fall-through mode (`cfg_sel` low after reset), the oldest word appears on `rd_word` without a read, and `rd_avail` is high while it is shown. The word stays stable until it is read.
- R8: A read takes place only on a rising `rd_clk` edge with `rd_csn` low and `rd_en` high.
- R9: While `rd_csn` is high, `rd_word` is all zeros.
- R10: Reset clears all pointers, the pending half-word and the output register. After reset, `wr_room`=1, `wr_afull_n`=1, `rd_avail`=0 and `rd_aempty_n`=0.
- R11: Words are read in the order in which their second half-words were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low reset for both domains |
| cfg_sel | input | 1 | Packing order during reset, timing mode after reset |
| wr_en | input | 1 | Write one half-word on this edge |
| wr_half | input | 18 | Half-word to write |
| wr_room | output | 1 | High when a write can be accepted |
| wr_afull_n | output | 1 | Low when free words are at most AF_OFS |
| rd_csn | input | 1 | Active-low read chip select |
| rd_en | input | 1 | Read enable |
| rd_word | output | 36 | Read data, zero while deselected |
| rd_avail | output | 1 | Standard: not empty. Fall-through: output valid |
| rd_aempty_n | output | 1 | Low when stored words are at most AE_OFS |

## Verification
The hardest state to reach is a lone half-word that sits in the packing register while the read side sees nothing. A second hard state is a write attempted into a full buffer, which must also disturb nothing. Directed sequences create both cases. The bench writes one half, waits well past the synchronizer delay, and then checks that no word is reported. It later forces two extra half-words into a full buffer and drains the buffer to prove that they were dropped. Random bursts in fall-through mode, with random gaps inside each pair, run reads and writes against a reference queue.

// File: rtl/hw_pack_fifo.sv
module hw_pack_fifo #(
  parameter int DEPTH  = 16,
  parameter int AF_OFS = 2,
  parameter int AE_OFS = 2,
  parameter int HW     = 18
) (
  input  logic            wr_clk,
  input  logic            rd_clk,
  input  logic            rst_n,
  input  logic            cfg_sel,
  input  logic            wr_en,
  input  logic [HW-1:0]   wr_half,
  output logic            wr_room,
  output logic            wr_afull_n,
  input  logic            rd_csn,
  input  logic            rd_en,
  output logic [2*HW-1:0] rd_word,
  output logic            rd_avail,
  output logic            rd_aempty_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int WW = 2 * HW;
  localparam logic [AW:0] DEPTHV = (AW+1)'(DEPTH);
  localparam logic [AW:0] AFV    = (AW+1)'(AF_OFS);
  localparam logic [AW:0] AEV    = (AW+1)'(AE_OFS);

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [WW-1:0] mem [DEPTH];
  logic [AW:0]   wbin, wgray, rq1, rq2;
  logic [AW:0]   rbin, rgray, wq1, wq2;
  logic          be_q, pend, dvalid;
  logic [HW-1:0] hold;
  logic [WW-1:0] dout;

  // write domain
  wire [AW:0] wused = wbin - g2b(rq2);
  wire [AW:0] wfree = DEPTHV - wused;
  wire [AW:0] wnext = wbin + 1'b1;
  wire        wacc  = wr_en && wr_room;

  assign wr_room    = wfree != '0;
  assign wr_afull_n = wfree > AFV;

  always_ff @(posedge wr_clk)
    if (!rst_n) be_q <= cfg_sel;

  always_ff @(posedge wr_clk or negedge rst_n)
    if (!rst_n) begin
      pend  <= 1'b0;
      hold  <= '0;
      wbin  <= '0;
      wgray <= '0;
      rq1   <= '0;
      rq2   <= '0;
    end else begin
      rq1 <= rgray;
      rq2 <= rq1;
      if (wacc) begin
        if (!pend) begin
          hold <= wr_half;
          pend <= 1'b1;
        end else begin
          pend  <= 1'b0;
          wbin  <= wnext;
          wgray <= wnext ^ (wnext >> 1);
        end
      end
    end

  always_ff @(posedge wr_clk)
    if (wacc && pend)
      mem[wbin[AW-1:0]] <= be_q ? {hold, wr_half} : {wr_half, hold};

  // read domain
  wire        fwft  = !cfg_sel;
  wire        rd_go = !rd_csn && rd_en;
  wire [AW:0] rcnt  = g2b(wq2) - rbin;
  wire [AW:0] rnext = rbin + 1'b1;
  wire        load  = (rcnt != '0) && (fwft ? (!dvalid || rd_go) : rd_go);
  wire [AW:0] rlvl  = fwft ? rcnt + {{AW{1'b0}}, dvalid} : rcnt;

  assign rd_avail    = fwft ? dvalid : (rcnt != '0);
  assign rd_aempty_n = rlvl > AEV;
  assign rd_word     = rd_csn ? '0 : dout;

  always_ff @(posedge rd_clk or negedge rst_n)
    if (!rst_n) begin
      rbin   <= '0;
      rgray  <= '0;
      wq1    <= '0;
      wq2    <= '0;
      dout   <= '0;
      dvalid <= 1'b0;
    end else begin
      wq1 <= wgray;
      wq2 <= wq1;
      if (load) begin
        dout   <= mem[rbin[AW-1:0]];
        rbin   <= rnext;
        rgray  <= rnext ^ (rnext >> 1);
        dvalid <= 1'b1;
      end else if (rd_go) begin
        dvalid <= 1'b0;
      end
    end

  AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!rst_n) wused <= DEPTHV); // R3
  AST_FULL_AFULL: assert property (@(posedge wr_clk) disable iff (!rst_n) !wr_room |-> !wr_afull_n); // R4
  AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (!rst_n) rcnt <= DEPTHV); // R11
  AST_IDLE_NO_POP: assert property (@(posedge rd_clk) disable iff (!rst_n) (!fwft && !rd_go) |=> $stable(rbin)); // R8
  AST_EMPTY_AEMPTY: assert property (@(posedge rd_clk) disable iff (!rst_n) (!fwft && !rd_avail) |-> !rd_aempty_n); // R5
  AST_FWFT_HOLD: assert property (@(posedge rd_clk) disable iff (!rst_n) (fwft && dvalid && !rd_go) |=> (dvalid && $stable(dout))); // R7
endmodule

// File: tb/hw_pack_fifo_test.sv
module hw_pack_fifo_test;
  localparam int DEPTH = 16, AF_OFS = 2, AE_OFS = 2;

  logic wr_clk = 0, rd_clk = 0, rst_n = 0, cfg_sel = 1;
  logic wr_en = 0, rd_csn = 0, rd_en = 0;
  logic [17:0] wr_half = '0;
  logic wr_room, wr_afull_n, rd_avail, rd_aempty_n;
  logic [35:0] rd_word;

  int passed = 0, total = 0;
  bit be_mode = 1;
  logic [35:0] q[$];

  always #2 wr_clk = ~wr_clk;
  always #3 rd_clk = ~rd_clk;

  hw_pack_fifo #(.DEPTH(DEPTH), .AF_OFS(AF_OFS), .AE_OFS(AE_OFS)) uut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .cfg_sel(cfg_sel),
    .wr_en(wr_en), .wr_half(wr_half), .wr_room(wr_room), .wr_afull_n(wr_afull_n),
    .rd_csn(rd_csn), .rd_en(rd_en), .rd_word(rd_word), .rd_avail(rd_avail),
    .rd_aempty_n(rd_aempty_n));

  function automatic logic [35:0] pack(logic [17:0] a, logic [17:0] b, bit be);
    return be ? {a, b} : {b, a};
  endfunction

  task automatic chk(bit ok, string tag, logic [35:0] act, logic [35:0] exp);
    total++;
    if (ok) passed++;
    else $display("FAIL %s actual=%h expected=%h", tag, act, exp);
  endtask

  task automatic do_reset(bit be, bit std);
    rst_n = 0; cfg_sel = be; wr_en = 0; rd_en = 0; rd_csn = 0;
    repeat (5) @(posedge rd_clk);
    @(negedge wr_clk); rst_n = 1;
    @(negedge wr_clk); cfg_sel = std;
    be_mode = be; q.delete();
  endtask

  task automatic wait_sync();
    repeat (8) @(posedge rd_clk);
    repeat (8) @(posedge wr_clk);
    @(negedge rd_clk);
  endtask

  task automatic put_half(logic [17:0] h);
    @(negedge wr_clk);
    while (!wr_room) @(negedge wr_clk);
    wr_en = 1; wr_half = h;
    @(negedge wr_clk); wr_en = 0;
  endtask

  task automatic put_word();
    logic [17:0] a, b;
    a = 18'($urandom); b = 18'($urandom);
    put_half(a);
    repeat ($urandom % 3) @(negedge wr_clk);
    put_half(b);
    q.push_back(pack(a, b, be_mode));
  endtask

  task automatic read_std(string tag);
    logic [35:0] e;
    @(negedge rd_clk);
    while (!rd_avail) @(negedge rd_clk);
    rd_en = 1; @(negedge rd_clk); rd_en = 0;
    e = q.pop_front();
    chk(rd_word == e, tag, rd_word, e);
  endtask

  task automatic read_fwft(string tag);
    logic [35:0] e, g;
    @(negedge rd_clk);
    while (!rd_avail) @(negedge rd_clk);
    g = rd_word; e = q.pop_front();
    chk(g == e, tag, g, e);
    rd_en = 1; @(negedge rd_clk); rd_en = 0;
  endtask

  initial begin
    repeat (150000) @(posedge wr_clk);
    total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    do_reset(1, 1);
    wait_sync();
    chk(wr_room == 1, "R10 wr_room", 36'(wr_room), 1);
    chk(wr_afull_n == 1, "R10 wr_afull_n", 36'(wr_afull_n), 1);
    chk(rd_avail == 0, "R10 rd_avail", 36'(rd_avail), 0);
    chk(rd_aempty_n == 0, "R10 rd_aempty_n", 36'(rd_aempty_n), 0);
    chk(rd_word == 0, "R10 rd_word", rd_word, 0);

    // R1 R6 R11: big-endian packing, standard reads in order
    put_word(); put_word();
    wait_sync();
    chk(rd_avail == 1, "R6 avail with data", 36'(rd_avail), 1);
    read_std("R1 big-endian word");
    read_std("R11 second word");

    // R2: lone half-word is invisible
    put_half(18'h2A5A5);
    wait_sync();
    chk(rd_avail == 0, "R2 lone half not visible", 36'(rd_avail), 0);
    put_half(18'h1C3C3);
    q.push_back(pack(18'h2A5A5, 18'h1C3C3, 1));
    wait_sync();
    chk(rd_avail == 1, "R2 pair visible", 36'(rd_avail), 1);
    read_std("R2 pair data");

    // R8 R9: deselected read does nothing, output zero
    put_word(); wait_sync();
    rd_csn = 1; rd_en = 1;
    repeat (5) @(negedge rd_clk);
    chk(rd_word == 0, "R9 zero while deselected", rd_word, 0);
    rd_csn = 0; rd_en = 0;
    @(negedge rd_clk);
    chk(rd_avail == 1, "R8 no read while deselected", 36'(rd_avail), 1);
    read_std("R8 word kept");

    // R5 R4 R3: thresholds and full
    wait_sync();
    for (int i = 0; i < AE_OFS; i++) put_word();
    wait_sync();
    chk(rd_aempty_n == 0, "R5 at AE_OFS", 36'(rd_aempty_n), 0);
    put_word(); wait_sync();
    chk(rd_aempty_n == 1, "R5 above AE_OFS", 36'(rd_aempty_n), 1);
    while (q.size() < DEPTH - AF_OFS - 1) put_word();
    wait_sync();
    chk(wr_afull_n == 1, "R4 free AF_OFS+1", 36'(wr_afull_n), 1);
    put_word(); wait_sync();
    chk(wr_afull_n == 0, "R4 free AF_OFS", 36'(wr_afull_n), 0);
    while (q.size() < DEPTH) put_word();
    wait_sync();
    chk(wr_room == 0, "R3 full", 36'(wr_room), 0);
    @(negedge wr_clk); wr_en = 1; wr_half = 18'h3FFFF;
    @(negedge wr_clk); wr_half = 18'h00001;
    @(negedge wr_clk); wr_en = 0;
    for (int i = 0; i < DEPTH; i++) read_std("R3 drain after refused write");
    wait_sync();
    chk(rd_avail == 0, "R3 refused write not stored", 36'(rd_avail), 0);

    // R1: little-endian in standard mode
    do_reset(0, 1);
    put_word(); wait_sync();
    read_std("R1 little-endian word");

    // R7: fall-through mode, little-endian
    do_reset(0, 0);
    put_word(); wait_sync();
    chk(rd_avail == 1, "R7 output valid without read", 36'(rd_avail), 1);
    chk(rd_word == q[0], "R7 word shown without read", rd_word, q[0]);
    chk(rd_aempty_n == 0, "R5 fwft count one", 36'(rd_aempty_n), 0);
    read_fwft("R7 fwft read");

    // R11: random traffic in fall-through mode
    for (int i = 0; i < 300; i++) begin
      if (($urandom % 2 == 1) && q.size() < DEPTH) put_word();
      else if (q.size() != 0) read_fwft("R11 random order");
    end
    while (q.size() != 0) read_fwft("R11 final drain");

    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end
endmodule